// File: doc/BRIEF.md
# Debug Run/Halt Controller

This block decides whether the processor core runs or sits halted for on-chip debugging. A halt can come from the serial debug host or from the breakpoint unit. The controller then stalls the core and waits for the instruction in flight to retire. It stores the address of the next instruction to run and reports entry into the halted state with a single-cycle pulse.

While halted, the host may overwrite the stored address, execute one instruction, or resume. Both step and resume start with a one-cycle redirect that sends the core to the stored address before the stall lifts. Peripherals and timers keep running the whole time. Only interrupt servicing is held off, through a gate output, and it reopens one cycle after the core is back in normal execution.

Top module: `dbg_run_ctrl`

## Requirements
- R1: In run (stall_o low, bkpt_mask_o low), a high host_halt_i or bkpt_hit_i raises stall_o from the next cycle. stall_o then stays high, and halted_o stays low, until retire_i is seen.
- R2: A retire_i while halting stores ret_next_pc_i and enters halted (halted_o high). Every entry into halted, including the return from a step, pulses debug_entered_o for exactly the first halted cycle.
- R3: pc_wr_i while halted replaces the stored address with pc_wdata_i. Without a write, the stored address is held.
- R4: resume_cmd_i while halted gives exactly one cycle with redirect_o high, stall_o high and redirect_pc_o equal to the stored address. stall_o is low from the following cycle.
- R5: Without a host write, the redirect address equals the ret_next_pc_i value stored when the halt completed.
- R6: step_cmd_i while halted gives one redirect cycle. stall_o then goes low with bkpt_mask_o high until one retire_i. stall_o is high during that retire cycle. The controller then returns to halted and stores the new ret_next_pc_i.
- R7: irq_en_o is high out of reset. It goes low from the cycle after a halt request is accepted. It stays low through halted, stepping and redirect, and through the first run cycle after resume. It is high again from the second run cycle.
- R8: Halt requests outside run are ignored. Step, resume and address writes outside halted are ignored.
- R9: If resume and step arrive in the same halted cycle, the resume wins.
- R10: After reset the controller is in run: stall_o, redirect_o, halted_o, debug_entered_o and bkpt_mask_o are low.
- R11: bkpt_mask_o is high in every state except run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_halt_i | input | 1 | Halt request from the debug host |
| bkpt_hit_i | input | 1 | Breakpoint hit from the comparator unit |
| step_cmd_i | input | 1 | Single-step command strobe |
| resume_cmd_i | input | 1 | Resume command strobe |
| pc_wr_i | input | 1 | Host write of the stored address |
| pc_wdata_i | input | AW | New stored address |
| retire_i | input | 1 | Core retired an instruction |
| ret_next_pc_i | input | AW | Address of the next instruction after the retire |
| stall_o | output | 1 | Core stall |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | AW | Redirect target, equal to the stored address |
| bkpt_mask_o | output | 1 | Suppress breakpoint matching |
| irq_en_o | output | 1 | Interrupt servicing gate |
| halted_o | output | 1 | Controller is halted |
| debug_entered_o | output | 1 | One-cycle pulse on entry into halted |

## Verification
The bench sweeps both halt sources against four exit paths: plain resume, address rewrite then resume, a step followed by resume, and simultaneous step and resume. It uses several retire delays and addresses. A design that loses the stored address, or lets a host write leak in while running, sends the redirect to the wrong address. A design that lets the step run on shows a low stall in the retire cycle, or never returns to halted. Opening the interrupt gate together with the stall release, or letting a step win over a resume, shows up as a wrong irq_en_o in the first two run cycles.

// File: rtl/dbg_ctrl_pkg.sv
package dbg_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_HALTING  = 3'd1,
    ST_HALTED   = 3'd2,
    ST_STEPPING = 3'd3,
    ST_RESUMING = 3'd4
  } dbg_state_e;
endpackage

// File: rtl/dbg_fsm.sv
module dbg_fsm
  import dbg_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_req_i,
  input  logic       step_i,
  input  logic       resume_i,
  input  logic       retire_i,
  output dbg_state_e state_o,
  output dbg_state_e state_next_o,
  output logic       capture_o,
  output logic       entered_o
);
  dbg_state_e state_q, state_d;
  logic       step_q, step_d;
  logic       entered_q;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    unique case (state_q)
      ST_RUN:      if (halt_req_i) state_d = ST_HALTING;
      ST_HALTING:  if (retire_i) state_d = ST_HALTED;
      ST_HALTED: begin
        if (resume_i) begin
          state_d = ST_RESUMING;
          step_d  = 1'b0;
        end else if (step_i) begin
          state_d = ST_RESUMING;
          step_d  = 1'b1;
        end
      end
      ST_RESUMING: state_d = step_q ? ST_STEPPING : ST_RUN;
      ST_STEPPING: if (retire_i) state_d = ST_HALTED;
      default:     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      step_q    <= 1'b0;
      entered_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      step_q    <= step_d;
      entered_q <= (state_d == ST_HALTED) && (state_q != ST_HALTED);
    end
  end

  // retire closes both a halt drain and a single step
  assign capture_o    = retire_i && ((state_q == ST_HALTING) || (state_q == ST_STEPPING));
  assign state_o      = state_q;
  assign state_next_o = state_d;
  assign entered_o    = entered_q;
endmodule

// File: rtl/dbg_pc_hold.sv
module dbg_pc_hold #(
  parameter int unsigned      AW       = 16,
  parameter logic [AW-1:0]    RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [AW-1:0] cap_pc_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_pc_i,
  output logic [AW-1:0] pc_o
);
  logic [AW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= RESET_PC;
    else if (capture_i) pc_q <= cap_pc_i;
    else if (wr_i)      pc_q <= wr_pc_i;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/dbg_irq_gate.sv
module dbg_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_now_i,
  input  logic run_next_i,
  output logic irq_en_o
);
  logic en_q;

  // open only after a full cycle of run, close as soon as run is left
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b1;
    else         en_q <= run_now_i && run_next_i;
  end

  assign irq_en_o = en_q;
endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
  import dbg_ctrl_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_halt_i,
  input  logic          bkpt_hit_i,
  input  logic          step_cmd_i,
  input  logic          resume_cmd_i,
  input  logic          pc_wr_i,
  input  logic [AW-1:0] pc_wdata_i,
  input  logic          retire_i,
  input  logic [AW-1:0] ret_next_pc_i,
  output logic          stall_o,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic          bkpt_mask_o,
  output logic          irq_en_o,
  output logic          halted_o,
  output logic          debug_entered_o
);
  dbg_state_e state, state_next;
  logic       capture;
  logic       in_run, in_halted, in_step;

  dbg_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_req_i   (host_halt_i | bkpt_hit_i),
    .step_i       (step_cmd_i),
    .resume_i     (resume_cmd_i),
    .retire_i     (retire_i),
    .state_o      (state),
    .state_next_o (state_next),
    .capture_o    (capture),
    .entered_o    (debug_entered_o)
  );

  assign in_run    = (state == ST_RUN);
  assign in_halted = (state == ST_HALTED);
  assign in_step   = (state == ST_STEPPING);

  dbg_pc_hold #(.AW(AW), .RESET_PC(RESET_PC)) i_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .cap_pc_i  (ret_next_pc_i),
    .wr_i      (pc_wr_i && in_halted),
    .wr_pc_i   (pc_wdata_i),
    .pc_o      (redirect_pc_o)
  );

  dbg_irq_gate i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_now_i  (in_run),
    .run_next_i (state_next == ST_RUN),
    .irq_en_o   (irq_en_o)
  );

  // during a step the stall returns in the retire cycle so only one instruction issues
  assign stall_o     = !(in_run || (in_step && !retire_i));
  assign redirect_o  = (state == ST_RESUMING);
  assign bkpt_mask_o = !in_run;
  assign halted_o    = in_halted;
endmodule

// File: rtl/dbg_run_ctrl_chk.sv
module dbg_run_ctrl_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_halt_i,
  input logic          bkpt_hit_i,
  input logic          pc_wr_i,
  input logic [AW-1:0] pc_wdata_i,
  input logic          stall_o,
  input logic          redirect_o,
  input logic [AW-1:0] redirect_pc_o,
  input logic          bkpt_mask_o,
  input logic          irq_en_o,
  input logic          halted_o,
  input logic          debug_entered_o
);
  p_halt_stalls_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && !bkpt_mask_o && (host_halt_i || bkpt_hit_i)) |=> (stall_o && !halted_o));

  p_entered_halted_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_entered_o |-> halted_o);

  p_entered_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_entered_o |=> !debug_entered_o);

  p_pc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !pc_wr_i) |=> $stable(redirect_pc_o));

  p_pc_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && pc_wr_i) |=> (redirect_pc_o == $past(pc_wdata_i)));

  p_redirect_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> stall_o);

  p_redirect_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);

  p_irq_halted_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o || redirect_o) |-> !irq_en_o);

  p_irq_late_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !irq_en_o);

  p_no_cmd_in_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && !bkpt_mask_o) |=> !redirect_o);

  p_mask_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> bkpt_mask_o);
endmodule

bind dbg_run_ctrl dbg_run_ctrl_chk #(.AW(AW)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .host_halt_i     (host_halt_i),
  .bkpt_hit_i      (bkpt_hit_i),
  .pc_wr_i         (pc_wr_i),
  .pc_wdata_i      (pc_wdata_i),
  .stall_o         (stall_o),
  .redirect_o      (redirect_o),
  .redirect_pc_o   (redirect_pc_o),
  .bkpt_mask_o     (bkpt_mask_o),
  .irq_en_o        (irq_en_o),
  .halted_o        (halted_o),
  .debug_entered_o (debug_entered_o)
);

// File: tb/test_dbg_run_ctrl.sv
module test_dbg_run_ctrl;
  localparam int AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          host_halt_i = 1'b0, bkpt_hit_i = 1'b0;
  logic          step_cmd_i = 1'b0, resume_cmd_i = 1'b0, pc_wr_i = 1'b0;
  logic [AW-1:0] pc_wdata_i = '0;
  logic          retire_i = 1'b0;
  logic [AW-1:0] ret_next_pc_i = '0;
  logic          stall_o, redirect_o, bkpt_mask_o, irq_en_o, halted_o, debug_entered_o;
  logic [AW-1:0] redirect_pc_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  dbg_run_ctrl #(.AW(AW)) i_dbg_run_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  // enter halted from run; src 0 = host, 1 = breakpoint
  task automatic do_halt(int src, int wait_n, logic [AW-1:0] pc);
    if (src == 0) host_halt_i = 1'b1; else bkpt_hit_i = 1'b1;
    cyc();
    host_halt_i = 1'b0; bkpt_hit_i = 1'b0;
    chk("R1 stall after request", stall_o, 1);
    chk("R7 irq closed while halting", irq_en_o, 0);
    chk("R11 mask while halting", bkpt_mask_o, 1);
    for (int i = 0; i < wait_n; i++) begin
      resume_cmd_i = 1'b1; pc_wr_i = 1'b1; pc_wdata_i = 16'hdead;
      cyc();
      resume_cmd_i = 1'b0; pc_wr_i = 1'b0;
      chk("R1 stall held before retire", stall_o, 1);
      chk("R8 resume ignored while halting", redirect_o, 0);
      chk("R1 not halted before retire", halted_o, 0);
    end
    retire_i = 1'b1; ret_next_pc_i = pc;
    cyc();
    retire_i = 1'b0;
    chk("R2 halted", halted_o, 1);
    chk("R2 entry pulse", debug_entered_o, 1);
    // halt request while halted must be ignored
    host_halt_i = 1'b1; bkpt_hit_i = 1'b1;
    cyc();
    host_halt_i = 1'b0; bkpt_hit_i = 1'b0;
    chk("R2 pulse one cycle", debug_entered_o, 0);
    chk("R8 halt ignored in halted", halted_o, 1);
    chk("R7 irq closed in halted", irq_en_o, 0);
  endtask

  task automatic do_resume(logic [AW-1:0] exp_pc, bit with_step);
    resume_cmd_i = 1'b1; step_cmd_i = with_step;
    cyc();
    resume_cmd_i = 1'b0; step_cmd_i = 1'b0;
    chk("R4 redirect strobe", redirect_o, 1);
    chk("R4 stall during redirect", stall_o, 1);
    chk("R5 redirect address", redirect_pc_o, exp_pc);
    cyc();
    chk("R4 stall released", stall_o, 0);
    chk("R4 single redirect", redirect_o, 0);
    chk("R7 irq still closed", irq_en_o, 0);
    cyc();
    chk("R9 resume beats step / R7 irq open", irq_en_o, 1);
    chk("R11 mask off in run", bkpt_mask_o, 0);
  endtask

  task automatic do_step(logic [AW-1:0] exp_pc, logic [AW-1:0] new_pc, int wait_n);
    step_cmd_i = 1'b1;
    cyc();
    step_cmd_i = 1'b0;
    chk("R6 step redirect", redirect_o, 1);
    chk("R6 step redirect address", redirect_pc_o, exp_pc);
    for (int i = 0; i <= wait_n; i++) begin
      bkpt_hit_i = 1'b1;
      cyc();
      bkpt_hit_i = 1'b0;
      chk("R6 stall released for step", stall_o, 0);
      chk("R6 breakpoints masked in step", bkpt_mask_o, 1);
      chk("R7 irq closed in step", irq_en_o, 0);
    end
    retire_i = 1'b1; ret_next_pc_i = new_pc;
    #0.5;
    chk("R6 stall in retire cycle", stall_o, 1);
    cyc();
    retire_i = 1'b0;
    chk("R6 back to halted", halted_o, 1);
    chk("R2 entry pulse after step", debug_entered_o, 1);
    cyc();
    chk("R8 no extra entry from step halt", debug_entered_o, 0);
  endtask

  initial begin
    #1;
    chk("R10 reset stall", stall_o, 0);
    chk("R10 reset halted", halted_o, 0);
    chk("R10 reset mask", bkpt_mask_o, 0);
    chk("R10 reset redirect", redirect_o, 0);
    chk("R10 reset pulse", debug_entered_o, 0);
    #10 rst_ni = 1'b1;
    cyc();
    chk("R7 irq open after reset", irq_en_o, 1);
    // commands in run are ignored
    step_cmd_i = 1'b1; resume_cmd_i = 1'b1; pc_wr_i = 1'b1; pc_wdata_i = 16'hbeef;
    cyc();
    step_cmd_i = 1'b0; resume_cmd_i = 1'b0; pc_wr_i = 1'b0;
    chk("R8 commands ignored in run: redirect", redirect_o, 0);
    chk("R8 commands ignored in run: stall", stall_o, 0);

    for (int src = 0; src < 2; src++)
      for (int mode = 0; mode < 4; mode++)
        for (int k = 0; k < 4; k++) begin
          logic [AW-1:0] pc, wpc, spc;
          pc  = AW'(16'h0100 + src * 16'h0400 + mode * 16'h0040 + k * 4);
          wpc = pc ^ 16'h8000;
          spc = pc + 16'd2;
          do_halt(src, k % 3, pc);
          case (mode)
            0: do_resume(pc, 1'b0);
            1: begin
              pc_wr_i = 1'b1; pc_wdata_i = wpc;
              cyc();
              pc_wr_i = 1'b0;
              chk("R3 write keeps halted", halted_o, 1);
              do_resume(wpc, 1'b0);
            end
            2: begin
              do_step(pc, spc, k);
              do_resume(spc, 1'b0);
            end
            default: do_resume(pc, 1'b1);
          endcase
          repeat (2) cyc();
        end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule